// File: doc/BRIEF.md
# Boot-Remappable Bank Chip-Select Decoder

This block turns a 32-bit physical address into one of eight active-low bank chip selects, or into a select for a small internal boot SRAM. The lower gigabyte of the address space is cut into eight equal 128 MB regions. Each region has its own chip-select output.

Two boot-mode strap pins decide where the 4 KB boot SRAM appears. In NAND boot mode (straps 00) it sits at address zero and replaces external bank 0. In the other modes, bank 0 reaches external static memory at address zero, and the boot SRAM moves to 0x4000_0000.

Banks 6 and 7 can hold SDRAM. They form one contiguous region that starts at 0x3000_0000. Their split point comes from a 3-bit size code, held in a register that software writes at 0x4800_0028 through a simple configuration port. The decode is combinational from the address, the straps and the current size code. Any valid address that matches no target raises `miss`.

Top module: `bank_cs_decoder`

## Requirements
- R1: For a valid address below 0x3000_0000 (except bank 0 in NAND boot mode), exactly the chip select with index addr[29:27] is driven low.
- R2: At most one target (chip select or boot SRAM) is active at a time. When addr_valid is low, all chip selects are high and bootram_sel and miss are low.
- R3: With boot_mode 00 (NAND boot), addresses 0x0000_0000..0x0000_0FFF assert bootram_sel. The rest of the first 128 MB asserts no chip select and raises miss. The 0x4000_0000 boot window also misses in this mode.
- R4: With boot_mode 01, 10 or 11, the whole first 128 MB drives bank_cs_n[0] low, and 0x4000_0000..0x4000_0FFF asserts bootram_sel.
- R5: The size code gives the per-bank size S as follows: 0 = 128 MB, 1 = 2 MB, 2 = 4 MB, 3 = 8 MB, 4 = 16 MB, 5 = 32 MB, 6 = 64 MB, 7 = 2 MB.
- R6: Inside 0x3000_0000..0x3FFF_FFFF, offsets below S select bank 6 (bank_cs_n[6] low), and offsets from S to 2S-1 select bank 7. Offsets from 2S upward select nothing and raise miss.
- R7: A cycle with cfg_we high and cfg_addr equal to 0x4800_0028 stores cfg_wdata[2:0] at the clock edge, and the decode uses the new code from the next cycle on. A write to any other cfg_addr changes nothing.
- R8: The size code resets to 2 (4 MB). cfg_rdata returns the code zero-extended to 32 bits while cfg_addr is 0x4800_0028, and returns zero for any other cfg_addr.
- R9: miss is high exactly when addr_valid is high and no target matches. This includes every address at or above 0x4000_0000 outside the boot window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_mode | input | 2 | Boot-mode straps; 00 selects NAND boot |
| addr_valid | input | 1 | Address on `addr` is to be decoded |
| addr | input | 32 | Physical address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 32 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| bank_cs_n | output | 8 | Active-low bank chip selects |
| bootram_sel | output | 1 | Boot SRAM selected |
| miss | output | 1 | Valid address matched no target |

## Verification
A write to the size register and a decode that depends on it can happen in the same cycle. The bench provokes this by presenting an address in the bank 6/7 window while a new code is being written. It checks that the select still follows the old split before the edge and the new split after it. Around this directed case, seeded random addresses are aimed at region edges, at the S and 2S boundaries and at both boot windows. These cover all strap values and size codes, and each result is compared against a bench model of the map.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

   typedef enum logic [1:0] {
      BOOT_NAND   = 2'b00,
      BOOT_ROM16  = 2'b01,
      BOOT_ROM32  = 2'b10,
      BOOT_SPARE  = 2'b11
   } boot_mode_e;

   localparam int unsigned LG_W = 5;

   // log2 of the per-bank byte count for a size code; code 0 is the full bank
   function automatic logic [LG_W-1:0] size_log2(input logic [2:0] code,
                                                 input logic [LG_W-1:0] full_lg);
      logic [LG_W-1:0] r;
      case (code)
         3'd0:    r = full_lg;
         3'd7:    r = LG_W'(21);
         default: r = LG_W'(20) + LG_W'(code);
      endcase
      return r;
   endfunction

endpackage

// File: rtl/bcd_size_reg.sv
module bcd_size_reg #(
   parameter int unsigned          ADDR_W   = 32,
   parameter int unsigned          DATA_W   = 32,
   parameter int unsigned          CODE_W   = 3,
   parameter logic [ADDR_W-1:0]    REG_ADDR = 32'h4800_0028,
   parameter logic [CODE_W-1:0]    RST_CODE = 3'b010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   output logic [CODE_W-1:0] size_code
);

   if (CODE_W >= DATA_W) begin : g_bad_width
      $error("bcd_size_reg: CODE_W must be narrower than DATA_W");
   end

   logic reg_hit;
   logic unused_wdata;

   assign reg_hit      = (cfg_addr == REG_ADDR);
   assign unused_wdata = ^cfg_wdata[DATA_W-1:CODE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                size_code <= RST_CODE;
      else if (cfg_we && reg_hit) size_code <= cfg_wdata[CODE_W-1:0];
   end

   assign cfg_rdata = reg_hit ? {{(DATA_W-CODE_W){1'b0}}, size_code} : '0;

   // R7: an addressed write lands on the next edge
   a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && reg_hit) |=> (size_code == $past(cfg_wdata[CODE_W-1:0])));

   // R7: anything else leaves the code alone
   a_r7_other_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && reg_hit) |=> $stable(size_code));

endmodule

// File: rtl/bcd_sdram_split.sv
module bcd_sdram_split
   import bcd_pkg::*;
#(
   parameter int unsigned BANK_BITS = 27,
   parameter int unsigned CODE_W    = 3,
   localparam int unsigned WIN_BITS = BANK_BITS + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                win_hit,
   input  logic [WIN_BITS-1:0] offset,
   input  logic [CODE_W-1:0]   size_code,
   output logic                lo_hit,
   output logic                hi_hit
);

   if (CODE_W != 3) begin : g_bad_code
      $error("bcd_sdram_split: size code table expects CODE_W of 3");
   end
   if (BANK_BITS < 22) begin : g_bad_bank
      $error("bcd_sdram_split: bank must be at least 4 MB");
   end

   localparam logic [WIN_BITS:0] ONE = {{WIN_BITS{1'b0}}, 1'b1};

   logic [LG_W-1:0]   lg;
   logic [WIN_BITS:0] lim_lo;
   logic [WIN_BITS:0] lim_hi;
   logic [WIN_BITS:0] off_ext;

   always_comb begin
      lg      = size_log2(size_code, LG_W'(BANK_BITS));
      lim_lo  = ONE << lg;
      lim_hi  = lim_lo << 1;
      off_ext = {1'b0, offset};
      lo_hit  = win_hit && (off_ext < lim_lo);
      hi_hit  = win_hit && !(off_ext < lim_lo) && (off_ext < lim_hi);
   end

   // R6: the two halves never claim the same address
   a_r6_halves_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !(lo_hit && hi_hit));

   // R6: outside the window neither half responds
   a_r6_window_only: assert property (@(posedge clk) disable iff (!rst_n)
      !win_hit |-> !(lo_hit || hi_hit));

endmodule

// File: rtl/bcd_region_decode.sv
module bcd_region_decode #(
   parameter int unsigned       ADDR_W      = 32,
   parameter int unsigned       NUM_BANKS   = 8,
   parameter int unsigned       BANK_BITS   = 27,
   parameter int unsigned       BOOT_BITS   = 12,
   parameter logic [ADDR_W-1:0] BOOT_HI_BASE = 32'h4000_0000,
   localparam int unsigned      IDX_W       = $clog2(NUM_BANKS),
   localparam int unsigned      TOP_LSB     = BANK_BITS + IDX_W
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic [NUM_BANKS-1:0] region_hit,
   output logic                 boot_low,
   output logic                 boot_high
);

   if (TOP_LSB >= ADDR_W) begin : g_bad_map
      $error("bcd_region_decode: bank map exceeds address width");
   end
   if (BOOT_BITS >= BANK_BITS) begin : g_bad_boot
      $error("bcd_region_decode: boot SRAM must be smaller than a bank");
   end

   localparam logic [ADDR_W-BOOT_BITS-1:0] HI_TAG = BOOT_HI_BASE[ADDR_W-1:BOOT_BITS];

   logic in_low_map;
   logic [IDX_W-1:0] idx;

   assign in_low_map = (addr[ADDR_W-1:TOP_LSB] == '0);
   assign idx        = addr[TOP_LSB-1:BANK_BITS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_region
      assign region_hit[b] = in_low_map && (idx == IDX_W'(b));
   end

   assign boot_low  = (addr[ADDR_W-1:BOOT_BITS] == '0);
   assign boot_high = (addr[ADDR_W-1:BOOT_BITS] == HI_TAG);

endmodule

// File: rtl/bank_cs_decoder.sv
module bank_cs_decoder
   import bcd_pkg::*;
#(
   parameter int unsigned       ADDR_W       = 32,
   parameter int unsigned       DATA_W       = 32,
   parameter int unsigned       NUM_BANKS    = 8,
   parameter int unsigned       BANK_BITS    = 27,
   parameter int unsigned       BOOT_BITS    = 12,
   parameter int unsigned       SDRAM_BANK   = 6,
   parameter int unsigned       CODE_W       = 3,
   parameter logic [ADDR_W-1:0] BOOT_HI_BASE = 32'h4000_0000,
   parameter logic [ADDR_W-1:0] SIZE_REG_ADDR = 32'h4800_0028,
   parameter logic [CODE_W-1:0] SIZE_RST     = 3'b010,
   localparam int unsigned      WIN_BITS     = BANK_BITS + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           boot_mode,
   input  logic                 addr_valid,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 cfg_we,
   input  logic [ADDR_W-1:0]    cfg_addr,
   input  logic [DATA_W-1:0]    cfg_wdata,
   output logic [DATA_W-1:0]    cfg_rdata,
   output logic [NUM_BANKS-1:0] bank_cs_n,
   output logic                 bootram_sel,
   output logic                 miss
);

   if ((NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("bank_cs_decoder: NUM_BANKS must be a power of two");
   end
   if ((SDRAM_BANK % 2) != 0 || SDRAM_BANK + 2 > NUM_BANKS) begin : g_bad_sdram
      $error("bank_cs_decoder: SDRAM pair must be aligned and inside the map");
   end

   logic [CODE_W-1:0]    size_code;
   logic [NUM_BANKS-1:0] region_hit;
   logic                 boot_low, boot_high;
   logic                 nand_boot;
   logic                 win_hit, lo_hit, hi_hit;
   logic [NUM_BANKS-1:0] cs;
   logic                 boot_hit;

   bcd_size_reg #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W),
      .REG_ADDR(SIZE_REG_ADDR), .RST_CODE(SIZE_RST)
   ) u_size (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .size_code(size_code)
   );

   bcd_region_decode #(
      .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK_BITS(BANK_BITS),
      .BOOT_BITS(BOOT_BITS), .BOOT_HI_BASE(BOOT_HI_BASE)
   ) u_region (
      .addr(addr), .region_hit(region_hit),
      .boot_low(boot_low), .boot_high(boot_high)
   );

   assign win_hit = addr_valid && (region_hit[SDRAM_BANK] || region_hit[SDRAM_BANK+1]);

   bcd_sdram_split #(
      .BANK_BITS(BANK_BITS), .CODE_W(CODE_W)
   ) u_split (
      .clk(clk), .rst_n(rst_n), .win_hit(win_hit),
      .offset(addr[WIN_BITS-1:0]), .size_code(size_code),
      .lo_hit(lo_hit), .hi_hit(hi_hit)
   );

   assign nand_boot = (boot_mode_e'(boot_mode) == BOOT_NAND);
   assign boot_hit  = addr_valid && (nand_boot ? boot_low : boot_high);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
      if (b == 0) begin : g_boot_bank
         assign cs[b] = addr_valid && region_hit[b] && !nand_boot;
      end else if (b == SDRAM_BANK) begin : g_sdram_lo
         assign cs[b] = lo_hit;
      end else if (b == SDRAM_BANK + 1) begin : g_sdram_hi
         assign cs[b] = hi_hit;
      end else begin : g_static
         assign cs[b] = addr_valid && region_hit[b];
      end
   end

   assign bank_cs_n   = ~cs;
   assign bootram_sel = boot_hit;
   assign miss        = addr_valid && !(|cs) && !boot_hit;

   // R2: one target at most
   a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({~bank_cs_n, bootram_sel}));

   // R2: nothing moves without a valid address
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_valid |-> (&bank_cs_n && !bootram_sel && !miss));

   // R3: bank 0 is never reached in NAND boot
   a_r3_bank0_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_mode == 2'b00) |-> bank_cs_n[0]);

   // R4: high boot window answers in the other modes
   a_r4_boot_high: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && boot_mode != 2'b00 && addr[ADDR_W-1:BOOT_BITS] == BOOT_HI_BASE[ADDR_W-1:BOOT_BITS])
      |-> bootram_sel);

   // R9: a miss excludes every select
   a_r9_miss_alone: assert property (@(posedge clk) disable iff (!rst_n)
      miss |-> (&bank_cs_n && !bootram_sel));

endmodule

// File: tb/bank_cs_decoder_tb.sv
`timescale 1ns/1ps
module bank_cs_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  boot_mode = 2'b01;
   logic        addr_valid = 1'b0;
   logic [31:0] addr = '0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [7:0]  bank_cs_n;
   logic        bootram_sel;
   logic        miss;

   int checks = 0;
   int errors = 0;
   logic [2:0] cur_code = 3'd2;

   localparam logic [31:0] REG_A = 32'h4800_0028;

   always #2.5 clk = ~clk;

   bank_cs_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .addr_valid(addr_valid),
      .addr(addr), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .bank_cs_n(bank_cs_n), .bootram_sel(bootram_sel),
      .miss(miss)
   );

   function automatic longint size_bytes(input logic [2:0] code);
      case (code)
         3'd0: return 64'd134217728;
         3'd1: return 64'd2097152;
         3'd2: return 64'd4194304;
         3'd3: return 64'd8388608;
         3'd4: return 64'd16777216;
         3'd5: return 64'd33554432;
         3'd6: return 64'd67108864;
         default: return 64'd2097152;
      endcase
   endfunction

   // {miss, boot, cs_n[7:0]}
   function automatic logic [9:0] model(input logic [31:0] a, input logic [1:0] m,
                                        input logic [2:0] code, input logic v);
      logic [7:0] csn;
      longint off, s;
      csn = 8'hFF;
      if (!v) return {1'b0, 1'b0, csn};
      if (a < 32'h3000_0000) begin
         if (a < 32'h0800_0000 && m == 2'b00) begin
            if (a < 32'h0000_1000) return {1'b0, 1'b1, csn};
            return {1'b1, 1'b0, csn};
         end
         csn[a / 32'h0800_0000] = 1'b0;
         return {1'b0, 1'b0, csn};
      end
      if (a < 32'h4000_0000) begin
         off = longint'(a) - 64'h3000_0000;
         s   = size_bytes(code);
         if (off < s)          csn[6] = 1'b0;
         else if (off < 2 * s) csn[7] = 1'b0;
         else                  return {1'b1, 1'b0, csn};
         return {1'b0, 1'b0, csn};
      end
      if (m != 2'b00 && a >= 32'h4000_0000 && a < 32'h4000_1000)
         return {1'b0, 1'b1, csn};
      return {1'b1, 1'b0, csn};
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s addr=%h mode=%b code=%0d got=%h exp=%h",
                  req, addr, boot_mode, cur_code, got, exp);
      end
   endtask

   task automatic probe(input string req, input logic [31:0] a, input logic v);
      @(negedge clk);
      addr = a;
      addr_valid = v;
      #1;
      check(req, {22'd0, miss, bootram_sel, bank_cs_n},
            {22'd0, model(a, boot_mode, cur_code, v)});
   endtask

   task automatic write_cfg(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_addr = a;
      cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (a == REG_A) cur_code = d[2:0];
   endtask

   function automatic logic [31:0] pick_addr(input logic [2:0] code);
      int unsigned r;
      longint s;
      r = $urandom % 6;
      s = size_bytes(code);
      case (r)
         0: return $urandom;
         1: return $urandom % 32'h4000_0000;
         2: return 32'h3000_0000 + 32'(s) + 32'($urandom % 5) - 32'd2;
         3: return 32'h3000_0000 + 32'(2 * s) + 32'($urandom % 5) - 32'd2;
         4: return 32'h4000_0000 + 32'($urandom % 32'h2000);
         default: return 32'($urandom % 32'h2000) + (($urandom % 2) != 0 ? 32'h07FF_E000 : 32'h0);
      endcase
   endfunction

   initial begin
      void'($urandom(32'd1357));
      repeat (3) @(posedge clk);
      @(negedge clk);
      cfg_addr = REG_A;
      #1;
      // R8: reset value and readback
      check("R8 reset code", cfg_rdata, 32'd2);
      check("R2 idle outputs", {22'd0, miss, bootram_sel, bank_cs_n}, {22'd0, 2'b00, 8'hFF});
      rst_n = 1'b1;

      // R8: other address reads zero
      @(negedge clk);
      cfg_addr = 32'h4800_002C;
      #1;
      check("R8 other read zero", cfg_rdata, 32'd0);

      // R7: write elsewhere ignored, then addressed write
      write_cfg(32'h4800_002C, 32'h5);
      cfg_addr = REG_A;
      #1;
      check("R7 stray write ignored", cfg_rdata, 32'd2);
      write_cfg(REG_A, 32'hFFFF_FFF5);
      cfg_addr = REG_A;
      #1;
      check("R7 write stored low bits", cfg_rdata, 32'd5);

      // directed corners
      boot_mode = 2'b00;
      probe("R3 nand boot top", 32'h0000_0FFF, 1'b1);
      probe("R3 nand boot bottom", 32'h0000_0000, 1'b1);
      probe("R3 nand bank0 miss", 32'h0000_1000, 1'b1);
      probe("R3 nand high window miss", 32'h4000_0000, 1'b1);
      probe("R1 bank1 start", 32'h0800_0000, 1'b1);
      boot_mode = 2'b01;
      probe("R4 bank0 end", 32'h07FF_FFFF, 1'b1);
      probe("R4 boot high end", 32'h4000_0FFF, 1'b1);
      probe("R9 past boot window", 32'h4000_1000, 1'b1);
      probe("R9 register address not decoded", REG_A, 1'b1);
      probe("R1 bank5 end", 32'h2FFF_FFFF, 1'b1);
      probe("R2 invalid quiet", 32'h1000_0000, 1'b0);
      boot_mode = 2'b11;
      probe("R4 spare mode bank0", 32'h0000_0000, 1'b1);

      // same-cycle write and dependent decode
      write_cfg(REG_A, 32'd2);
      @(negedge clk);
      addr = 32'h3060_0000;
      addr_valid = 1'b1;
      cfg_we = 1'b1;
      cfg_addr = REG_A;
      cfg_wdata = 32'd3;
      #1;
      check("R7 old split before edge", {24'd0, bank_cs_n}, {24'd0, 8'h7F});
      @(negedge clk);
      cfg_we = 1'b0;
      cur_code = 3'd3;
      #1;
      check("R7 new split after edge", {24'd0, bank_cs_n}, {24'd0, 8'hBF});

      // R5/R6 every code at its boundaries, then random mix
      for (int m = 0; m < 4; m++) begin
         boot_mode = 2'(m);
         for (int c = 0; c < 8; c++) begin
            longint s;
            write_cfg(REG_A, 32'(c));
            s = size_bytes(3'(c));
            probe("R5 R6 last of bank6", 32'h3000_0000 + 32'(s) - 32'd1, 1'b1);
            probe("R5 R6 first of bank7", 32'h3000_0000 + 32'(s), 1'b1);
            probe("R6 last of bank7", 32'h3000_0000 + 32'(2 * s) - 32'd1, 1'b1);
            probe("R6 above bank7", 32'h3000_0000 + 32'(2 * s), 1'b1);
            for (int k = 0; k < 60; k++) begin
               probe("R1 R3 R4 R6 R9 random", pick_addr(3'(c)), ($urandom % 8) != 0);
            end
         end
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule